// File: doc/BRIEF.md
# Register-Test Branch Condition Flag

This block settles whether a conditional branch will be taken. It receives a two-bit test selector, taken from the low half of a four-bit register-specifier field of the current instruction, together with the 32-bit value of the register under test as it appears on an operand bus. From these it works out one of four register tests: equal to zero, not zero, sign bit clear, or sign bit set.

The result is stored in a single flag register, but only on a clock edge where the capture strobe is high. The instruction sequencer reads the stored flag afterwards and uses it to decide whether the program counter takes the branch target. The block does not compute the branch target, does not update the program counter and does not access the register file.

Top module: `brcond_flag`

## Requirements
- R1: A synchronous reset, active high, clears the flag to 0 (not taken). The cleared state holds while reset stays high, including on edges where the capture strobe is also high.
- R2: Selector code 2'b00 gives a taken result (1) exactly when the 32-bit operand equals zero.
- R3: Selector code 2'b01 gives a taken result exactly when the operand is not zero.
- R4: Selector code 2'b10 gives a taken result exactly when operand bit 31 is 0. This covers zero and positive values.
- R5: Selector code 2'b11 gives a taken result exactly when operand bit 31 is 1.
- R6: The flag takes the evaluated result on a rising clock edge where the capture strobe is high. That value appears on the output right after the edge, with one cycle of latency.
- R7: On an edge where the capture strobe is low, the flag keeps its previous value, whatever the selector and operand are doing.
- R8: The selector input is the full four-bit field. Only its bits [1:0] choose the test. Bits [3:2] have no effect on the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| condField | input | 4 | Register-specifier field from the instruction; bits [1:0] select the test |
| operand | input | 32 | Value of the register under test, taken from the bus |
| captureEn | input | 1 | Capture strobe; when high, the flag loads the evaluated result |
| takeBranch | output | 1 | Registered condition flag; 1 means taken |

## Verification
A wrong internal state in this block has only one place to show itself: the takeBranch output, on the edge right after a capture. Examples are a bad test decode, a sign check on the wrong bit, or a flag that still follows its input while the strobe is low. The bench compares the output against a behavioural model on every clock. Any error therefore shows up within one cycle of the capture or hold that caused it. Hold cycles are run with inputs that would flip the result, so that a leaking enable cannot go unnoticed.

// File: rtl/brcond_pkg.sv
package brcond_pkg;
  localparam int DATA_W  = 32;
  localparam int FIELD_W = 4;
  localparam int CODE_W  = 2;

  typedef enum logic [CODE_W-1:0] {
    TEST_ZERO    = 2'b00,
    TEST_NONZERO = 2'b01,
    TEST_NONNEG  = 2'b10,
    TEST_NEG     = 2'b11
  } testCode_t;

  typedef struct packed {
    logic clear;
    logic load;
  } flagCtrl_t;
endpackage

// File: rtl/brcond_ctrl.sv
module brcond_ctrl
  import brcond_pkg::*;
(
  input  logic      rst,
  input  logic      captureEn,
  output flagCtrl_t ctrl
);
  always_comb begin
    ctrl.clear = rst;
    ctrl.load  = captureEn && !rst;
  end
endmodule

// File: rtl/brcond_dp.sv
module brcond_dp
  import brcond_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FIELD_W
) (
  input  logic          clk,
  input  flagCtrl_t     ctrl,
  input  logic [FW-1:0] condField,
  input  logic [DW-1:0] operand,
  output logic          flagQ
);
  localparam int SIGN_BIT = DW - 1;

  testCode_t code;
  logic isZero;
  logic isNeg;
  logic result;

  assign code   = testCode_t'(condField[CODE_W-1:0]);
  assign isZero = (operand == '0);
  assign isNeg  = operand[SIGN_BIT];

  always_comb begin
    case (code)
      TEST_ZERO:    result = isZero;
      TEST_NONZERO: result = !isZero;
      TEST_NONNEG:  result = !isNeg;
      TEST_NEG:     result = isNeg;
      default:      result = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear)     flagQ <= 1'b0;
    else if (ctrl.load) flagQ <= result;
  end
endmodule

// File: rtl/brcond_flag.sv
module brcond_flag
  import brcond_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [3:0]  condField,
  input  logic [31:0] operand,
  input  logic        captureEn,
  output logic        takeBranch
);
  flagCtrl_t ctrl;

  brcond_ctrl u_ctrl (
    .rst(rst), .captureEn(captureEn), .ctrl(ctrl)
  );

  brcond_dp #(.DW(DATA_W), .FW(FIELD_W)) u_dp (
    .clk(clk), .ctrl(ctrl), .condField(condField),
    .operand(operand), .flagQ(takeBranch)
  );
endmodule

// File: rtl/brcond_flag_chk.sv
module brcond_flag_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  condField,
  input logic [31:0] operand,
  input logic        captureEn,
  input logic        takeBranch
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !takeBranch);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!captureEn && !$past(rst)) |=> $stable(takeBranch));

  assert_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (captureEn && condField[1:0] == 2'b00) |=> (takeBranch == ($past(operand) == 32'd0)));

  assert_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    (captureEn && condField[1:0] == 2'b01) |=> (takeBranch == ($past(operand) != 32'd0)));

  assert_nonneg_R4: assert property (@(posedge clk) disable iff (rst)
    (captureEn && condField[1:0] == 2'b10) |=> (takeBranch == !$past(operand[31])));

  assert_neg_R5: assert property (@(posedge clk) disable iff (rst)
    (captureEn && condField[1:0] == 2'b11) |=> (takeBranch == $past(operand[31])));
endmodule

bind brcond_flag brcond_flag_chk u_chk (
  .clk(clk), .rst(rst), .condField(condField), .operand(operand),
  .captureEn(captureEn), .takeBranch(takeBranch)
);

// File: tb/brcond_flag_test.sv
module brcond_flag_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  condField = '0;
  logic [31:0] operand = '0;
  logic        captureEn = 1'b0;
  logic        takeBranch;

  int testsRun = 0;
  int testsFailed = 0;
  logic modelFlag = 1'b0;
  bit done = 1'b0;

  brcond_flag uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic evalRef(input logic [3:0] f, input logic [31:0] v);
    int sel = f % 4;
    if (sel == 0) return v == 0;
    if (sel == 1) return v != 0;
    if (sel == 2) return v < 32'h8000_0000;
    return v >= 32'h8000_0000;
  endfunction

  // reference model advances on every edge
  always @(posedge clk) begin
    if (rst) modelFlag <= 1'b0;
    else if (captureEn) modelFlag <= evalRef(condField, operand);
  end

  // compare every clock, away from the edge
  always @(negedge clk) begin
    if (!done) begin
      testsRun++;
      if (takeBranch !== modelFlag) begin
        testsFailed++;
        $display("FAIL per-cycle model R2 R3 R4 R5 R6 R7: got %b expected %b", takeBranch, modelFlag);
      end
    end
  end

  task automatic check(input string req, input logic exp);
    testsRun++;
    if (takeBranch !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %b expected %b", req, takeBranch, exp);
    end
  endtask

  task automatic step(input logic en, input logic [3:0] f, input logic [31:0] v);
    captureEn = en; condField = f; operand = v;
    @(posedge clk); #1;
  endtask

  initial begin
    #(CLK_PERIOD*20000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    rst = 1'b1;
    step(1'b1, 4'b0001, 32'h5);
    step(1'b1, 4'b0001, 32'h5);
    check("R1 reset with capture", 1'b0);
    rst = 1'b0;
    step(1'b0, 4'b0000, 32'h0);
    check("R1 idle after reset", 1'b0);

    step(1'b1, 4'b0000, 32'h0);          check("R2 zero taken", 1'b1);
    step(1'b1, 4'b0000, 32'h1);          check("R2 one not taken", 1'b0);
    step(1'b1, 4'b0000, 32'h8000_0000);  check("R2 msb not taken", 1'b0);
    step(1'b1, 4'b0001, 32'h0);          check("R3 zero not taken", 1'b0);
    step(1'b1, 4'b0001, 32'h8000_0000);  check("R3 msb taken", 1'b1);
    step(1'b1, 4'b0001, 32'h0000_0001);  check("R3 lsb taken", 1'b1);
    step(1'b1, 4'b0010, 32'h0);          check("R4 zero taken", 1'b1);
    step(1'b1, 4'b0010, 32'h7FFF_FFFF);  check("R4 max positive taken", 1'b1);
    step(1'b1, 4'b0010, 32'h8000_0000);  check("R4 min negative not taken", 1'b0);
    step(1'b1, 4'b0011, 32'hFFFF_FFFF);  check("R5 minus one taken", 1'b1);
    step(1'b1, 4'b0011, 32'h0);          check("R5 zero not taken", 1'b0);
    step(1'b1, 4'b0011, 32'h7FFF_FFFF);  check("R5 positive not taken", 1'b0);

    // R6: one-cycle latency, result visible right after capture edge
    step(1'b1, 4'b0001, 32'h40);         check("R6 capture latency", 1'b1);
    // R7: hold with inputs that would clear it
    step(1'b0, 4'b0000, 32'h40);         check("R7 hold high", 1'b1);
    step(1'b0, 4'b0011, 32'h1);          check("R7 hold high again", 1'b1);
    step(1'b1, 4'b0000, 32'h9);          check("R6 capture low", 1'b0);
    step(1'b0, 4'b0000, 32'h0);          check("R7 hold low", 1'b0);

    // R8: upper bits of field ignored
    step(1'b1, 4'b1100, 32'h0);          check("R8 upper bits with zero test", 1'b1);
    step(1'b1, 4'b1101, 32'h0);          check("R8 upper bits with nonzero test", 1'b0);
    step(1'b1, 4'b0110, 32'h8000_0001);  check("R8 upper bits with nonneg test", 1'b0);
    step(1'b1, 4'b1011, 32'h8000_0001);  check("R8 upper bits with neg test", 1'b1);

    // sweep all fields over a pattern set
    for (int f = 0; f < 16; f++) begin
      for (int k = 0; k < 6; k++) begin
        logic [31:0] v;
        v = (k == 0) ? 32'h0 : (k == 1) ? 32'h1 : (k == 2) ? 32'h8000_0000 :
            (k == 3) ? 32'hFFFF_FFFF : (k == 4) ? 32'h7FFF_FFFF : 32'h0010_0000;
        step(1'b1, f[3:0], v);
        check("R8 sweep", evalRef(f[3:0], v));
      end
    end

    // reset while set
    step(1'b1, 4'b0000, 32'h0);
    rst = 1'b1;
    step(1'b0, 4'b0000, 32'h0);          check("R1 mid-run reset", 1'b0);
    rst = 1'b0;
    step(1'b0, 4'b0000, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule